// File: doc/BRIEF.md
# Synchronous Channel Update Controller

This block keeps a group of PWM channels on one update schedule. The channels in the group share the period of channel 0. New period, dead-time and duty values held in each channel's shadow registers are applied to every member on the same clock cycle, right after a channel 0 period boundary. The block does not hold those values itself. It issues per-channel apply strobes, and each channel copies its own shadow registers when its strobe is high.

Software arms an update with a one-cycle unlock command. In the manual mode, that command covers period, dead time and duty. In the automatic modes, the command covers only period and dead time. Duty values are then applied on their own schedule, once every update-period-plus-one boundaries. In one automatic mode, each automatic update point also raises a request to a DMA engine, which reloads the duty shadow registers. The update-period value is written directly while channel 0 is stopped. While channel 0 runs, writes go through a shadow copy.

Top module: `sync_update_ctrl`

## Requirements
- R1: Only channels whose bit is set in `grp_mask_i` receive apply strobes. Bit i of every strobe vector belongs to channel i. The mask is sampled in the boundary cycle.
- R2: In mode 0 (manual), a pending unlock causes both `apply_pd_o` and `apply_duty_o` to equal the mask in the cycle after the next `per_bnd_i` pulse.
- R3: In modes 1, 2 and 3, a pending unlock produces only `apply_pd_o` at the next boundary. It produces no duty strobe.
- R4: `unlock_i` sets `unlock_pend_o` on the following cycle. The flag stays set until the boundary that performs the update, then clears by itself. A boundary with no pending unlock gives no period/dead-time strobe.
- R5: A write of `uper_wdata_i` while `ch0_en_i` is low appears on `uper_o` in the next cycle. A write while `ch0_en_i` is high is held in a shadow register and reaches `uper_o` only at the next automatic update point.
- R6: In the automatic modes, with channel 0 enabled, `apply_duty_o` equals the mask after every (`uper_o`+1)-th boundary, counted from the time channel 0 is enabled. The boundary count clears while channel 0 is disabled.
- R7: In mode 2 only, each automatic update point raises `dma_req_o` together with the duty strobe. It stays high until the cycle after `dma_ack_i` is sampled high.
- R8: Each apply strobe is high for exactly one cycle. That cycle is the one following the boundary pulse.
- R9: An unlock that arrives in the same cycle as a boundary is not applied at that boundary. It is applied at the next one.
- R10: Mode 3 behaves like mode 1, an automatic mode with no DMA request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_mask_i | input | N_CH | Group membership, one bit per channel |
| upd_mode_i | input | 2 | 0 manual, 1 auto, 2 auto with DMA, 3 same as 1 |
| ch0_en_i | input | 1 | Channel 0 running |
| uper_wr_i | input | 1 | Write strobe for the update period |
| uper_wdata_i | input | UPW | Update period write value |
| unlock_i | input | 1 | One-cycle unlock command |
| per_bnd_i | input | 1 | Channel 0 period boundary pulse |
| dma_ack_i | input | 1 | DMA acknowledge |
| apply_pd_o | output | N_CH | Apply period and dead-time shadow values |
| apply_duty_o | output | N_CH | Apply duty shadow value |
| dma_req_o | output | 1 | Request a duty reload by DMA |
| unlock_pend_o | output | 1 | Unlock armed and not yet performed |
| uper_o | output | UPW | Active update period |

## Verification
The bench counts boundaries exactly. A duty strobe arriving one boundary early or late shows that the comparison against the update period is off by one. It also arms an unlock in the same cycle as a boundary; a design that sets and consumes the flag together would apply at once. It writes the update period while channel 0 runs, which catches a design that bypasses the shadow copy. It checks that the unlock command in the automatic modes leaves duty alone, and that the DMA request holds until it is acknowledged and never appears in mode 1.

// File: rtl/sync_upd_pkg.sv
package sync_upd_pkg;
  typedef enum logic [1:0] {
    UPD_MANUAL   = 2'd0,
    UPD_AUTO     = 2'd1,
    UPD_AUTO_DMA = 2'd2,
    UPD_AUTO_ALT = 2'd3
  } upd_mode_e;

  function automatic logic is_auto(upd_mode_e m);
    return m != UPD_MANUAL;
  endfunction
endpackage

// File: rtl/sync_uper_reg.sv
module sync_uper_reg #(
  parameter int UPW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ch0_en_i,
  input  logic           wr_i,
  input  logic [UPW-1:0] wdata_i,
  input  logic           bnd_i,
  output logic [UPW-1:0] uper_o,
  output logic           wrap_o
);
  logic [UPW-1:0] uper_q, shad_q, cnt_q;
  logic           shad_vld_q;

  assign wrap_o = ch0_en_i && bnd_i && (cnt_q == uper_q);
  assign uper_o = uper_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!ch0_en_i) begin
      cnt_q <= '0;
    end else if (bnd_i) begin
      cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uper_q     <= '0;
      shad_q     <= '0;
      shad_vld_q <= 1'b0;
    end else begin
      if (wrap_o && shad_vld_q) begin
        uper_q     <= shad_q;
        shad_vld_q <= 1'b0;
      end
      if (wr_i) begin
        if (ch0_en_i) begin
          shad_q     <= wdata_i;
          shad_vld_q <= 1'b1;
        end else begin
          uper_q     <= wdata_i;
          shad_vld_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sync_unlock.sv
module sync_unlock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic bnd_i,
  output logic pend_o,
  output logic fire_o
);
  logic pend_q;

  assign fire_o = pend_q && bnd_i;
  assign pend_o = pend_q;

  // a set in the firing cycle arms the next boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q && !fire_o) || set_i;
  end
endmodule

// File: rtl/sync_strobe_gen.sv
module sync_strobe_gen
  import sync_upd_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] mask_i,
  input  upd_mode_e       mode_i,
  input  logic            fire_i,
  input  logic            wrap_i,
  input  logic            ack_i,
  output logic [N_CH-1:0] pd_o,
  output logic [N_CH-1:0] duty_o,
  output logic            req_o
);
  logic duty_trig, req_set, req_q;
  logic [N_CH-1:0] pd_q, duty_q;

  assign duty_trig = is_auto(mode_i) ? wrap_i : fire_i;
  assign req_set   = wrap_i && (mode_i == UPD_AUTO_DMA);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pd_q[i]   <= 1'b0;
        duty_q[i] <= 1'b0;
      end else begin
        pd_q[i]   <= fire_i && mask_i[i];
        duty_q[i] <= duty_trig && mask_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= (req_q && !ack_i) || req_set;
  end

  assign pd_o   = pd_q;
  assign duty_o = duty_q;
  assign req_o  = req_q;
endmodule

// File: rtl/sync_update_ctrl.sv
module sync_update_ctrl
  import sync_upd_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int UPW  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] grp_mask_i,
  input  logic [1:0]      upd_mode_i,
  input  logic            ch0_en_i,
  input  logic            uper_wr_i,
  input  logic [UPW-1:0]  uper_wdata_i,
  input  logic            unlock_i,
  input  logic            per_bnd_i,
  input  logic            dma_ack_i,
  output logic [N_CH-1:0] apply_pd_o,
  output logic [N_CH-1:0] apply_duty_o,
  output logic            dma_req_o,
  output logic            unlock_pend_o,
  output logic [UPW-1:0]  uper_o
);
  logic      wrap, fire;
  upd_mode_e mode;

  assign mode = upd_mode_e'(upd_mode_i);

  sync_uper_reg #(.UPW(UPW)) u_uper (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ch0_en_i(ch0_en_i),
    .wr_i    (uper_wr_i),
    .wdata_i (uper_wdata_i),
    .bnd_i   (per_bnd_i),
    .uper_o  (uper_o),
    .wrap_o  (wrap)
  );

  sync_unlock u_unlock (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (unlock_i),
    .bnd_i (per_bnd_i),
    .pend_o(unlock_pend_o),
    .fire_o(fire)
  );

  sync_strobe_gen #(.N_CH(N_CH)) u_strobe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mask_i(grp_mask_i),
    .mode_i(mode),
    .fire_i(fire),
    .wrap_i(wrap),
    .ack_i (dma_ack_i),
    .pd_o  (apply_pd_o),
    .duty_o(apply_duty_o),
    .req_o (dma_req_o)
  );
endmodule

// File: rtl/sync_update_ctrl_chk.sv
module sync_update_ctrl_chk #(
  parameter int N_CH = 4,
  parameter int UPW  = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] grp_mask_i,
  input logic [1:0]      upd_mode_i,
  input logic            ch0_en_i,
  input logic            uper_wr_i,
  input logic [UPW-1:0]  uper_wdata_i,
  input logic            unlock_i,
  input logic            per_bnd_i,
  input logic            dma_ack_i,
  input logic [N_CH-1:0] apply_pd_o,
  input logic [N_CH-1:0] apply_duty_o,
  input logic            dma_req_o,
  input logic            unlock_pend_o,
  input logic [UPW-1:0]  uper_o
);
  AST_MASK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((apply_pd_o | apply_duty_o) & ~$past(grp_mask_i)) == '0); // R1

  AST_STROBE_AFTER_BND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(apply_pd_o | apply_duty_o)) |-> $past(per_bnd_i)); // R8

  AST_UNLOCK_APPLIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlock_pend_o && per_bnd_i) |=> (apply_pd_o == $past(grp_mask_i))); // R2

  AST_UNLOCK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlock_pend_o && per_bnd_i && !unlock_i) |=> !unlock_pend_o); // R4

  AST_DMA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dma_req_o) |-> $past(dma_ack_i)); // R7

  AST_DMA_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_req_o) |-> ($past(upd_mode_i) == 2'd2)); // R7

  AST_UPER_STABLE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ch0_en_i) && !$past(per_bnd_i)) |-> $stable(uper_o)); // R5
endmodule

bind sync_update_ctrl sync_update_ctrl_chk #(.N_CH(N_CH), .UPW(UPW)) u_chk (.*);

// File: tb/tb_sync_update_ctrl.sv
`timescale 1ns/1ps
module tb_sync_update_ctrl;
  localparam int N_CH = 4;
  localparam int UPW  = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N_CH-1:0] grp_mask_i = '0;
  logic [1:0]      upd_mode_i = '0;
  logic            ch0_en_i = 1'b0;
  logic            uper_wr_i = 1'b0;
  logic [UPW-1:0]  uper_wdata_i = '0;
  logic            unlock_i = 1'b0;
  logic            per_bnd_i = 1'b0;
  logic            dma_ack_i = 1'b0;
  logic [N_CH-1:0] apply_pd_o, apply_duty_o;
  logic            dma_req_o, unlock_pend_o;
  logic [UPW-1:0]  uper_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  sync_update_ctrl #(.N_CH(N_CH), .UPW(UPW)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bnd();
    per_bnd_i = 1'b1;
    cyc();
    per_bnd_i = 1'b0;
  endtask

  task automatic unlock();
    unlock_i = 1'b1;
    cyc();
    unlock_i = 1'b0;
  endtask

  task automatic wr_uper(logic [UPW-1:0] v);
    uper_wr_i = 1'b1; uper_wdata_i = v;
    cyc();
    uper_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R4 reset pend", unlock_pend_o, 0);
    chk("R8 reset pd", apply_pd_o, 0);
    chk("R8 reset duty", apply_duty_o, 0);
    chk("R7 reset dma", dma_req_o, 0);
    chk("R5 reset uper", uper_o, 0);
  endtask

  task automatic t_manual();
    upd_mode_i = 2'd0; grp_mask_i = 4'b1010;
    bnd();
    chk("R4 no unlock no pd", apply_pd_o, 0);
    unlock();
    chk("R4 pend set", unlock_pend_o, 1);
    chk("R2 no strobe before bnd", apply_pd_o, 0);
    bnd();
    chk("R2 pd", apply_pd_o, 4'b1010);
    chk("R2 duty", apply_duty_o, 4'b1010);
    chk("R4 self clear", unlock_pend_o, 0);
    cyc();
    chk("R8 pd one cycle", apply_pd_o, 0);
    chk("R8 duty one cycle", apply_duty_o, 0);
  endtask

  task automatic t_same_cycle();
    upd_mode_i = 2'd0; grp_mask_i = 4'b0110;
    unlock_i = 1'b1; per_bnd_i = 1'b1;
    cyc();
    unlock_i = 1'b0; per_bnd_i = 1'b0;
    chk("R9 not applied same bnd", apply_pd_o, 0);
    chk("R9 still pending", unlock_pend_o, 1);
    bnd();
    chk("R9 applied next bnd", apply_pd_o, 4'b0110);
  endtask

  task automatic t_mask();
    upd_mode_i = 2'd0; grp_mask_i = 4'b0001;
    unlock();
    bnd();
    chk("R1 single member pd", apply_pd_o, 4'b0001);
    grp_mask_i = 4'b0000;
    unlock();
    bnd();
    chk("R1 empty group pd", apply_pd_o, 0);
    chk("R1 empty group duty", apply_duty_o, 0);
  endtask

  task automatic t_auto();
    upd_mode_i = 2'd1; grp_mask_i = 4'b1111;
    ch0_en_i = 1'b0; cyc();
    wr_uper(4'd2);
    chk("R5 direct write", uper_o, 2);
    ch0_en_i = 1'b1;
    bnd(); chk("R6 bnd1 no duty", apply_duty_o, 0);
    bnd(); chk("R6 bnd2 no duty", apply_duty_o, 0);
    bnd(); chk("R6 bnd3 duty", apply_duty_o, 4'b1111);
    chk("R6 no pd at auto point", apply_pd_o, 0);
    chk("R7 no dma in mode 1", dma_req_o, 0);
    unlock();
    bnd();
    chk("R3 unlock pd", apply_pd_o, 4'b1111);
    chk("R3 unlock no duty", apply_duty_o, 0);
    bnd();
    bnd();
    chk("R6 second period duty", apply_duty_o, 4'b1111);
  endtask

  task automatic t_shadow();
    upd_mode_i = 2'd1; grp_mask_i = 4'b0011;
    ch0_en_i = 1'b0; cyc();
    wr_uper(4'd2);
    ch0_en_i = 1'b1;
    wr_uper(4'd0);
    chk("R5 shadow held", uper_o, 2);
    bnd(); bnd();
    chk("R5 still held", uper_o, 2);
    bnd();
    chk("R5 shadow loaded", uper_o, 0);
    chk("R6 duty at load", apply_duty_o, 4'b0011);
    bnd();
    chk("R6 every bnd at uper 0", apply_duty_o, 4'b0011);
  endtask

  task automatic t_dma();
    grp_mask_i = 4'b0101;
    ch0_en_i = 1'b0; cyc();
    wr_uper(4'd0);
    ch0_en_i = 1'b1; upd_mode_i = 2'd2;
    bnd();
    chk("R7 dma raised", dma_req_o, 1);
    chk("R7 duty with dma", apply_duty_o, 4'b0101);
    cyc(3);
    chk("R7 dma held", dma_req_o, 1);
    dma_ack_i = 1'b1; cyc(); dma_ack_i = 1'b0;
    chk("R7 dma dropped", dma_req_o, 0);
    upd_mode_i = 2'd3;
    bnd();
    chk("R10 mode3 duty", apply_duty_o, 4'b0101);
    chk("R10 mode3 no dma", dma_req_o, 0);
    unlock(); bnd();
    chk("R10 mode3 unlock pd", apply_pd_o, 4'b0101);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc();
    t_reset();
    t_manual();
    t_same_cycle();
    t_mask();
    t_auto();
    t_shadow();
    t_dma();
    cyc(2);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule